// File: doc/BRIEF.md
# High-Speed Burst Lane Serializer

This block turns a byte stream into one high-speed burst on a single serial data lane. When a byte is offered while the lane rests in the Stop state, the block drives the low-power request levels. It then switches the lane to high-speed drive and sends a fixed synchronisation byte, followed by the payload bytes back to back, least significant bit first. After the final payload bit it inverts the line and holds that state for a trail interval. It then releases high-speed drive and returns the lines to Stop.

Bytes arrive on a valid/ready interface with a last flag. The block pulls each byte exactly at the final bit of the byte on the wire, so the bit stream has no gaps. If no byte is offered at that moment before the last flag has been seen, the block flags an underrun and closes the burst with a normal trail. A one-cycle completion pulse marks the first cycle in which a new burst may start. The request levels, trail length and Stop hold time are cycle-count parameters.

Top module: `hs_burst_ser`

## Requirements
- R1: With the lane idle, `in_valid` high starts a burst. `lp_state` (bit 1 = positive line, bit 0 = negative line) then reads 2'b01 for REQ_CYCLES cycles, then 2'b00 for REQ_CYCLES cycles, with `hs_en` low throughout. After that, `hs_en` rises.
- R2: The first eight high-speed cycles carry the sync pattern. Its bit values in time order are 0,0,0,1,1,1,0,1. While `hs_en` is high, `lp_state` reads 2'b00.
- R3: The payload bytes follow the sync pattern with no idle cycle, one bit per cycle, bit 0 of each byte first and bit 7 last.
- R4: In the cycle after the final sent bit, `hs_bit` becomes the inverse of that bit. It holds that value, with `hs_en` high, for exactly TRAIL_CYCLES cycles.
- R5: After the trail, `hs_en` is low and `lp_state` reads 2'b11 for EXIT_CYCLES cycles. In the next cycle, `burst_done` is high for exactly one cycle.
- R6: `in_ready` is high only in the cycle that carries bit 7 of the sync pattern, or bit 7 of a payload byte that was not flagged last. A byte is taken only when `in_valid` and `in_ready` are both high.
- R7: During the trail and the Stop hold, `in_ready` stays low and no new request starts even if `in_valid` is held high. The next burst's 2'b01 level appears in the cycle after the `burst_done` cycle.
- R8: If `in_ready` is high while `in_valid` is low, the burst ends. `underrun` pulses for one cycle in the first trail cycle, and the trail carries the inverse of the last bit sent.
- R9: After reset, `lp_state` is 2'b11, and `hs_en`, `in_ready`, `burst_done` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one lane bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A payload byte is offered |
| in_ready | output | 1 | The offered byte is taken this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the final one of the burst |
| lp_state | output | 2 | Single-ended line levels, bit 1 positive line, bit 0 negative line |
| hs_en | output | 1 | High-speed differential drive active |
| hs_bit | output | 1 | Differential bit value while `hs_en` is high |
| burst_done | output | 1 | One-cycle pulse when the lane is back in Stop and free |
| underrun | output | 1 | One-cycle pulse when the burst was cut short for lack of data |

## Verification
Some checks run on every cycle. They confirm that high-speed drive only begins out of the 2'b00 request level and always drops straight to 2'b11. They also confirm that the trail inverts the preceding bit and then holds it, that each shift moves the next byte bit onto the line, that `in_ready` is never high outside the sync and payload phases, and that the completion and underrun flags last one cycle. Some properties span a whole burst, and only the bench scenarios can show them. These are the exact bit order of sync and payload, the lengths of the request, trail and Stop intervals, where each handshake falls, and that a held-high `in_valid` waits for the completion cycle. The bench checks these for single-byte, multi-byte, underrun and back-to-back bursts.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    // Sync pattern; bit 0 leaves first, giving 0,0,0,1,1,1,0,1 on the wire.
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_HI,
        ST_REQ_LO,
        ST_SYNC,
        ST_DATA,
        ST_TRAIL,
        ST_EXIT
    } lane_st_e;

    typedef enum logic [1:0] {
        LP_00 = 2'b00,
        LP_01 = 2'b01,
        LP_10 = 2'b10,
        LP_11 = 2'b11
    } lp_lvl_e;

    typedef struct packed {
        logic    hs_en;
        logic    hs_bit;
        lp_lvl_e lp;
    } lane_drive_t;

    function automatic lane_drive_t lp_only(input lp_lvl_e lvl);
        lane_drive_t d;
        d.hs_en  = 1'b0;
        d.hs_bit = 1'b0;
        d.lp     = lvl;
        return d;
    endfunction

    function automatic lane_drive_t hs_drive(input logic b);
        lane_drive_t d;
        d.hs_en  = 1'b1;
        d.hs_bit = b;
        d.lp     = LP_00;
        return d;
    endfunction

endpackage

// File: rtl/hsb_dwell.sv
module hsb_dwell #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_DWELL_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/hsb_shifter.sv
module hsb_shifter
    import hsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              shift,
    output logic              out_bit,
    output logic              at_last
);

    logic [BYTE_W-1:0]    sh_q;
    logic [BIT_IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[BYTE_W-1:1]};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign out_bit = sh_q[0];
    assign at_last = (idx_q == BIT_IDX_W'(BYTE_W - 1));

    AST_SHIFT_NEXT_BIT: assert property (@(posedge clk) disable iff (rst)
        ($past(shift) && !$past(load)) |-> (out_bit == $past(sh_q[1]))); // R3

    AST_LOAD_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (out_bit == $past(din[0]) && !at_last)); // R3

endmodule

// File: rtl/hsb_lane_fsm.sv
module hsb_lane_fsm
    import hsb_pkg::*;
#(
    parameter int REQ_CYCLES   = 4,
    parameter int TRAIL_CYCLES = 6,
    parameter int EXIT_CYCLES  = 3,
    parameter int CNT_W        = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             sh_bit,
    input  logic             sh_at_last,
    output logic             sh_load,
    output logic             sh_sync,
    output logic             sh_shift,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output lane_drive_t      drive,
    output logic             burst_done,
    output logic             underrun
);

    localparam logic [CNT_W-1:0] REQ_M1   = CNT_W'(REQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] TRAIL_M1 = CNT_W'(TRAIL_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXIT_M1  = CNT_W'(EXIT_CYCLES - 1);

    lane_st_e st_q, st_d;
    logic     last_q;
    logic     trail_q;
    logic     done_q;
    logic     under_q;
    logic     to_trail;
    logic     starve;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_sync  = 1'b0;
        sh_shift = 1'b0;
        in_ready = 1'b0;
        to_trail = 1'b0;
        starve   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid) begin
                    st_d     = ST_REQ_HI;
                    tmr_load = 1'b1;
                    tmr_val  = REQ_M1;
                end
            end
            ST_REQ_HI: begin
                if (tmr_expired) begin
                    st_d     = ST_REQ_LO;
                    tmr_load = 1'b1;
                    tmr_val  = REQ_M1;
                end
            end
            ST_REQ_LO: begin
                if (tmr_expired) begin
                    st_d    = ST_SYNC;
                    sh_load = 1'b1;
                    sh_sync = 1'b1;
                end
            end
            ST_SYNC, ST_DATA: begin
                if (!sh_at_last) begin
                    sh_shift = 1'b1;
                end else if (st_q == ST_DATA && last_q) begin
                    to_trail = 1'b1;
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        st_d    = ST_DATA;
                        sh_load = 1'b1;
                    end else begin
                        to_trail = 1'b1;
                        starve   = 1'b1;
                    end
                end
                if (to_trail) begin
                    st_d     = ST_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = TRAIL_M1;
                end
            end
            ST_TRAIL: begin
                if (tmr_expired) begin
                    st_d     = ST_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = EXIT_M1;
                end
            end
            ST_EXIT: begin
                if (tmr_expired) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            last_q  <= 1'b0;
            trail_q <= 1'b0;
            done_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            done_q  <= (st_q == ST_EXIT) && tmr_expired;
            under_q <= starve;
            if (sh_load && !sh_sync) begin
                last_q <= in_last;
            end
            if (to_trail) begin
                trail_q <= ~sh_bit;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_REQ_HI:        drive = lp_only(LP_01);
            ST_REQ_LO:        drive = lp_only(LP_00);
            ST_SYNC, ST_DATA: drive = hs_drive(sh_bit);
            ST_TRAIL:         drive = hs_drive(trail_q);
            default:          drive = lp_only(LP_11);
        endcase
    end

    assign burst_done = done_q;
    assign underrun   = under_q;

    AST_HS_FROM_LP00: assert property (@(posedge clk) disable iff (rst)
        $rose(drive.hs_en) |-> ($past(drive.lp) == LP_00)); // R1

    AST_HS_ENDS_IN_STOP: assert property (@(posedge clk) disable iff (rst)
        $fell(drive.hs_en) |-> (drive.lp == LP_11)); // R5

    AST_TRAIL_INVERTS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TRAIL && $past(st_q) != ST_TRAIL) |-> (drive.hs_bit != $past(drive.hs_bit))); // R4

    AST_TRAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TRAIL && $past(st_q) == ST_TRAIL) |-> $stable(drive.hs_bit)); // R4

    AST_READY_IN_HS_ONLY: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (st_q == ST_SYNC || st_q == ST_DATA)); // R6

    AST_NO_REQ_WHILE_CLOSING: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TRAIL || st_q == ST_EXIT) |=> (drive.lp != LP_01)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done); // R5

    AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (st_q == ST_TRAIL && $past(st_q) != ST_TRAIL)); // R8

endmodule

// File: rtl/hs_burst_ser.sv
module hs_burst_ser
    import hsb_pkg::*;
#(
    parameter int REQ_CYCLES   = 4,
    parameter int TRAIL_CYCLES = 6,
    parameter int EXIT_CYCLES  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic [1:0] lp_state,
    output logic       hs_en,
    output logic       hs_bit,
    output logic       burst_done,
    output logic       underrun
);

    localparam int MAX_A = (REQ_CYCLES > TRAIL_CYCLES) ? REQ_CYCLES : TRAIL_CYCLES;
    localparam int MAX_DWELL = (MAX_A > EXIT_CYCLES) ? MAX_A : EXIT_CYCLES;
    localparam int CNT_W = (MAX_DWELL < 2) ? 1 : $clog2(MAX_DWELL);

    logic              sh_bit, sh_at_last, sh_load, sh_sync, sh_shift;
    logic              tmr_expired, tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [BYTE_W-1:0] sh_din;
    lane_drive_t       drive;

    assign sh_din = sh_sync ? SYNC_BYTE : in_data;

    hsb_lane_fsm #(
        .REQ_CYCLES  (REQ_CYCLES),
        .TRAIL_CYCLES(TRAIL_CYCLES),
        .EXIT_CYCLES (EXIT_CYCLES),
        .CNT_W       (CNT_W)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .sh_bit     (sh_bit),
        .sh_at_last (sh_at_last),
        .sh_load    (sh_load),
        .sh_sync    (sh_sync),
        .sh_shift   (sh_shift),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .drive      (drive),
        .burst_done (burst_done),
        .underrun   (underrun)
    );

    hsb_shifter shifter_i (
        .clk    (clk),
        .rst    (rst),
        .load   (sh_load),
        .din    (sh_din),
        .shift  (sh_shift),
        .out_bit(sh_bit),
        .at_last(sh_at_last)
    );

    hsb_dwell #(.CNT_W(CNT_W)) dwell_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    assign lp_state = drive.lp;
    assign hs_en    = drive.hs_en;
    assign hs_bit   = drive.hs_bit;

endmodule

// File: tb/hs_burst_ser_tb_top.sv
module hs_burst_ser_tb_top;

    localparam int REQ   = 2;
    localparam int TRAIL = 3;
    localparam int EXITC = 2;
    localparam int MAXP  = 128;
    localparam logic [7:0] SYNC = 8'hB8;

    // [37:35] byte count, [34:32] bytes supplied before input starves, [31:0] bytes (byte 0 lowest)
    localparam logic [37:0] VEC [0:3] = '{
        {3'd1, 3'd1, 32'h0000_00A5},
        {3'd2, 3'd2, 32'h0000_3C81},
        {3'd4, 3'd4, 32'hDEAD_BEEF},
        {3'd3, 3'd3, 32'h0000_FF00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic [1:0] lp_state;
    logic       hs_en, hs_bit, burst_done, underrun;

    int nchk = 0;
    int nerr = 0;

    logic [1:0] o_lp  [MAXP];
    logic       o_en  [MAXP];
    logic       o_bit [MAXP];
    logic       o_rdy [MAXP];
    logic       o_und [MAXP];

    always #4 clk = ~clk;

    hs_burst_ser #(
        .REQ_CYCLES  (REQ),
        .TRAIL_CYCLES(TRAIL),
        .EXIT_CYCLES (EXITC)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .lp_state  (lp_state),
        .hs_en     (hs_en),
        .hs_bit    (hs_bit),
        .burst_done(burst_done),
        .underrun  (underrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_burst(input logic [31:0] data, input int nb, input int supply,
                             input bit keep, input string name);
        int pos = 0;
        int done_pos = -1;
        int given = 0;
        bit started = 0;
        bit under = (supply < nb);
        int sent = under ? supply : nb;
        int base_hs = 2 * REQ;
        int base_tr = base_hs + 8 + 8 * sent;
        int len = base_tr + TRAIL + EXITC;
        logic last_bit = data[8 * (sent - 1) + 7];
        int m_req = 0, m_sync = 0, m_data = 0, m_tr = 0, m_ex = 0, m_rdy = 0, m_und = 0;
        in_valid = 1'b1;
        in_data  = data[7:0];
        in_last  = (nb == 1);
        for (int cyc = 0; cyc < 400 && done_pos < 0; cyc++) begin
            bit hand;
            @(negedge clk);
            if (!started && (lp_state != 2'b11 || hs_en)) started = 1;
            if (started && pos < MAXP) begin
                o_lp[pos]  = lp_state;
                o_en[pos]  = hs_en;
                o_bit[pos] = hs_bit;
                o_rdy[pos] = in_ready;
                o_und[pos] = underrun;
                if (burst_done) done_pos = pos;
                pos++;
            end
            hand = in_valid && in_ready;
            @(posedge clk);
            #1;
            if (hand) begin
                given++;
                if (given < supply) begin
                    in_data = data[8 * given +: 8];
                    in_last = (given == nb - 1);
                end else if (!keep) begin
                    in_valid = 1'b0;
                end
            end
        end
        chk(done_pos == len, {"R5 done position ", name}, done_pos, len);
        if (done_pos == len) begin
            for (int p = 0; p < len; p++) begin
                bit exp_rdy = 0;
                if (p < REQ) begin
                    if (o_lp[p] != 2'b01 || o_en[p]) m_req++;
                end else if (p < base_hs) begin
                    if (o_lp[p] != 2'b00 || o_en[p]) m_req++;
                end else if (p < base_hs + 8) begin
                    if (!o_en[p] || o_lp[p] != 2'b00 || o_bit[p] != SYNC[p - base_hs]) m_sync++;
                end else if (p < base_tr) begin
                    int q = p - base_hs - 8;
                    if (!o_en[p] || o_lp[p] != 2'b00 || o_bit[p] != data[q]) m_data++;
                end else if (p < base_tr + TRAIL) begin
                    if (!o_en[p] || o_lp[p] != 2'b00 || o_bit[p] != ~last_bit) m_tr++;
                end else begin
                    if (o_en[p] || o_lp[p] != 2'b11) m_ex++;
                end
                for (int k = 0; k <= (under ? sent : nb - 1); k++)
                    if (p == base_hs + 7 + 8 * k) exp_rdy = 1;
                if (o_rdy[p] != exp_rdy) m_rdy++;
                if (o_und[p] != (under && p == base_tr)) m_und++;
            end
            chk(m_req == 0, {"R1 request levels ", name}, m_req, 0);
            chk(m_sync == 0, {"R2 sync pattern ", name}, m_sync, 0);
            chk(m_data == 0, {"R3 payload bits ", name}, m_data, 0);
            chk(m_tr == 0, {"R4 trail state ", name}, m_tr, 0);
            chk(m_ex == 0, {"R5 stop hold ", name}, m_ex, 0);
            chk(m_rdy == 0, {"R6 ready cycles ", name}, m_rdy, 0);
            chk(m_und == 0, {"R8 underrun flag ", name}, m_und, 0);
            if (keep) chk(m_ex == 0 && m_rdy == 0, {"R7 held valid waits ", name}, m_ex + m_rdy, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R9: reset state, and idle lane with no offer
        repeat (3) begin
            @(negedge clk);
            chk(lp_state == 2'b11 && !hs_en && !in_ready && !burst_done && !underrun,
                "R9 idle after reset", {lp_state, hs_en, in_ready, burst_done, underrun}, 5'b11000);
        end

        for (int v = 0; v < 4; v++) begin
            run_burst(VEC[v][31:0], int'(VEC[v][37:35]), int'(VEC[v][34:32]), 1'b0, $sformatf("vec%0d", v));
            repeat (3) @(posedge clk);
            #1;
        end

        // R8: input starves after one byte, then after two bytes
        run_burst(32'h0012_3480, 3, 1, 1'b0, "starve1");
        repeat (2) @(posedge clk);
        #1;
        run_burst(32'h0012_3481, 3, 2, 1'b0, "starve2");
        repeat (2) @(posedge clk);
        #1;

        // R7: valid held high across the trail and stop hold, next burst follows at once
        run_burst(32'h0000_0055, 1, 1, 1'b1, "held_a");
        run_burst(32'h0000_7E01, 2, 2, 1'b0, "held_b");

        @(negedge clk);
        chk(lp_state == 2'b11 && !hs_en && !in_ready, "R9 idle at end", {lp_state, hs_en, in_ready}, 3'b110);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule